// File: doc/BRIEF.md
# Receive Destination Address Filter

This block makes the keep-or-drop decision for each incoming packet. It accepts the first received word of a packet over a valid/ready handshake. The receive status arrives alongside that word. The block compares the destination byte held in the upper part of the word against a configured host address. A registered decision comes back one cycle later.

An accepted packet leaves the block busy until the packet boundary is signalled, so exactly one decision is made per packet. A rejected packet produces a one-cycle purge command toward the receiver, and the block is at once ready for the next packet.

The block also holds a flag that the transmit side arms while it waits to retry. Any accepted packet clears that flag, which tells the transmitter that traffic arrived during its wait.

Top module: `rx_addr_filter`

## Requirements
- R1: The destination byte is `word_data[15:8]`. The low byte `word_data[7:0]` never affects the decision.
- R2: If `rx_status[7]` (collision seen by the receiver) or `rx_status[0]` (badly terminated packet) is set with the first word, the packet is purged with `dec_code` 0, whatever the addresses. No other status bit affects the decision.
- R3: With no error and `host_addr` equal to 0 (promiscuous), the packet is accepted with `dec_code` 2, for any destination, including 0.
- R4: With no error and a nonzero `host_addr` equal to the destination byte, the packet is accepted with `dec_code` 3.
- R5: With no error, a nonzero `host_addr` and a destination byte of 0 (broadcast), the packet is accepted with `dec_code` 4.
- R6: Every other packet is purged with `dec_code` 1. `purge_cmd` is high for exactly the one cycle in which `dec_valid` shows a purge, and at no other time. After a purge, `word_ready` is high in the very next cycle.
- R7: `dec_valid` is high for one cycle, namely the cycle after the clock edge at which `word_valid` and `word_ready` were both high, and at no other time. `dec_accept` is 1 for accept and 0 for purge.
- R8: After an accept, `word_ready` stays low and words are ignored until `pkt_end` is sampled high. If `pkt_end` is high at the same edge as the accepted first word, the block is ready again in the next cycle.
- R9: `tx_wait_flag` goes high one cycle after `tx_wait_arm` is sampled high. It reads 0 in the cycle in which `dec_valid` shows an accept. The clear wins over a simultaneous arm.
- R10: While `rst` is high, and in the first cycle after it falls, `dec_valid`, `dec_accept`, `purge_cmd` and `tx_wait_flag` are 0 and `word_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 8 | Configured station address, 0 means promiscuous |
| word_valid | input | 1 | First word of a packet is offered |
| word_ready | output | 1 | Block is idle and takes a first word |
| word_data | input | 16 | First received word, destination in upper byte |
| rx_status | input | 8 | Receive status presented with the first word |
| pkt_end | input | 1 | Current packet has finished |
| tx_wait_arm | input | 1 | Transmit side starts waiting for a retry |
| dec_valid | output | 1 | Decision strobe, one cycle |
| dec_accept | output | 1 | 1 keep, 0 purge, meaningful with dec_valid |
| dec_code | output | 3 | Reason: 0 error, 1 no match, 2 promiscuous, 3 own address, 4 broadcast |
| purge_cmd | output | 1 | One-cycle command putting the receiver in purge mode |
| tx_wait_flag | output | 1 | Armed by transmit side, cleared by any accepted packet |

## Verification
The properties take for granted that `rx_status` and `word_data` belong to the word being taken in the same cycle. They also assume that `word_valid` is low while `rst` is high, and that `host_addr` does not change between a handshake and its decision.

The directed stimulus follows these rules. It changes inputs only on the falling edge, it raises `word_valid` only after reset has ended, and it reprograms the host address only while no decision is pending. Words offered during a busy packet are held on purpose, so that the rule of ignoring them is exercised.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int WORD_W_DEF   = 16;
    localparam int ADDR_W_DEF   = 8;
    localparam int STAT_W_DEF   = 8;
    localparam int COLL_BIT_DEF = 7;
    localparam int TERM_BIT_DEF = 0;
    localparam int CODE_W       = 3;

    typedef enum logic [CODE_W-1:0] {
        CODE_ERR     = 3'd0,
        CODE_MISS    = 3'd1,
        CODE_PROMISC = 3'd2,
        CODE_MATCH   = 3'd3,
        CODE_BCAST   = 3'd4
    } verdict_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } fsm_e;

    typedef struct packed {
        logic     accept;
        verdict_e code;
    } decision_t;

    localparam decision_t DECISION_NONE = '{accept: 1'b0, code: CODE_ERR};

    function automatic logic verdict_keeps(verdict_e c);
        return (c == CODE_PROMISC) || (c == CODE_MATCH) || (c == CODE_BCAST);
    endfunction

endpackage

// File: rtl/rxf_classify.sv
module rxf_classify
    import rxf_pkg::*;
#(
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int STAT_W   = STAT_W_DEF,
    parameter int COLL_BIT = COLL_BIT_DEF,
    parameter int TERM_BIT = TERM_BIT_DEF
) (
    input  logic [ADDR_W-1:0] host,
    input  logic [ADDR_W-1:0] dest,
    input  logic [STAT_W-1:0] status,
    output decision_t         verdict
);

    localparam logic [STAT_W-1:0] ERR_MASK =
        STAT_W'((1 << COLL_BIT) | (1 << TERM_BIT));

    logic status_bad;
    logic host_zero;
    logic dest_zero;
    logic dest_same;

    assign status_bad = |(status & ERR_MASK);
    assign host_zero  = (host == '0);
    assign dest_zero  = (dest == '0);
    assign dest_same  = (dest == host);

    // priority chain: status errors, promiscuous, own address, broadcast
    verdict_e code;
    always_comb begin
        if (status_bad)
            code = CODE_ERR;
        else if (host_zero)
            code = CODE_PROMISC;
        else if (dest_same)
            code = CODE_MATCH;
        else if (dest_zero)
            code = CODE_BCAST;
        else
            code = CODE_MISS;
    end

    assign verdict.code   = code;
    assign verdict.accept = verdict_keeps(code);

endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
    import rxf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      word_valid,
    input  logic      pkt_end,
    input  decision_t verdict,
    output logic      word_ready,
    output logic      take,
    output logic      dec_valid_q,
    output decision_t dec_q,
    output logic      purge_q
);

    fsm_e state_q;
    fsm_e state_d;

    assign word_ready = (state_q == ST_IDLE);
    assign take       = word_valid && word_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take && verdict.accept && !pkt_end)
                    state_d = ST_BUSY;
            end
            ST_BUSY: begin
                if (pkt_end)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            dec_valid_q <= 1'b0;
            dec_q       <= DECISION_NONE;
            purge_q     <= 1'b0;
        end else begin
            state_q     <= state_d;
            dec_valid_q <= take;
            purge_q     <= take && !verdict.accept;
            if (take)
                dec_q <= verdict;
        end
    end

endmodule

// File: rtl/rxf_flag.sv
module rxf_flag (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic clear,
    output logic flag_q
);

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (clear)
            flag_q <= 1'b0;
        else if (arm)
            flag_q <= 1'b1;
    end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int WORD_W   = WORD_W_DEF,
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int STAT_W   = STAT_W_DEF,
    parameter int COLL_BIT = COLL_BIT_DEF,
    parameter int TERM_BIT = TERM_BIT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              word_valid,
    output logic              word_ready,
    input  logic [WORD_W-1:0] word_data,
    input  logic [STAT_W-1:0] rx_status,
    input  logic              pkt_end,
    input  logic              tx_wait_arm,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [CODE_W-1:0] dec_code,
    output logic              purge_cmd,
    output logic              tx_wait_flag
);

    localparam int LOW_W = WORD_W - ADDR_W;

    logic [ADDR_W-1:0] dest;
    logic              unused_low;
    decision_t         verdict;
    decision_t         dec_q;
    logic              take;
    logic              dec_valid_q;
    logic              purge_q;

    assign dest       = word_data[WORD_W-1 -: ADDR_W];
    assign unused_low = ^word_data[LOW_W-1:0];

    rxf_classify #(
        .ADDR_W  (ADDR_W),
        .STAT_W  (STAT_W),
        .COLL_BIT(COLL_BIT),
        .TERM_BIT(TERM_BIT)
    ) u_classify (
        .host   (host_addr),
        .dest   (dest),
        .status (rx_status),
        .verdict(verdict)
    );

    rxf_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .word_valid (word_valid),
        .pkt_end    (pkt_end),
        .verdict    (verdict),
        .word_ready (word_ready),
        .take       (take),
        .dec_valid_q(dec_valid_q),
        .dec_q      (dec_q),
        .purge_q    (purge_q)
    );

    rxf_flag u_flag (
        .clk   (clk),
        .rst   (rst),
        .arm   (tx_wait_arm),
        .clear (take && verdict.accept),
        .flag_q(tx_wait_flag)
    );

    assign dec_valid  = dec_valid_q;
    assign dec_accept = dec_valid_q && dec_q.accept;
    assign dec_code   = dec_q.code;
    assign purge_cmd  = purge_q;

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
    parameter int STAT_W   = 8,
    parameter int COLL_BIT = 7,
    parameter int TERM_BIT = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              word_valid,
    input logic              word_ready,
    input logic [STAT_W-1:0] rx_status,
    input logic              pkt_end,
    input logic              tx_wait_arm,
    input logic              dec_valid,
    input logic              dec_accept,
    input logic [2:0]        dec_code,
    input logic              purge_cmd,
    input logic              tx_wait_flag
);

    logic status_bad;
    assign status_bad = rx_status[COLL_BIT] || rx_status[TERM_BIT];

    // R7: a handshake always yields a decision in the next cycle
    p_decide_after_take_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(word_valid && word_ready)) |-> dec_valid);

    // R7: no decision without a preceding handshake
    p_no_spurious_decision_r7: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> $past(word_valid && word_ready));

    // R6: the purge command accompanies exactly the reject decisions
    p_purge_with_reject_r6: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> (purge_cmd == !dec_accept));

    p_purge_only_on_decision_r6: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> !purge_cmd);

    // R2: status errors dominate the address checks
    p_error_first_r2: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && $past(status_bad)) |-> (dec_code == 3'd0 && !dec_accept));

    // R8: after keeping a packet no further first word is taken
    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_accept && !$past(pkt_end)) |-> !word_ready);

    // R9: an accept clears the transmit wait flag
    p_flag_cleared_r9: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_accept) |-> !tx_wait_flag);

    p_flag_armed_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tx_wait_arm) && !(dec_valid && dec_accept)) |-> tx_wait_flag);

    // R10: outputs are quiet right after reset
    p_reset_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!dec_valid && !purge_cmd && !tx_wait_flag && word_ready));

endmodule

bind rx_addr_filter rxf_checker #(
    .STAT_W  (STAT_W),
    .COLL_BIT(COLL_BIT),
    .TERM_BIT(TERM_BIT)
) i_rxf_checker (
    .clk         (clk),
    .rst         (rst),
    .word_valid  (word_valid),
    .word_ready  (word_ready),
    .rx_status   (rx_status),
    .pkt_end     (pkt_end),
    .tx_wait_arm (tx_wait_arm),
    .dec_valid   (dec_valid),
    .dec_accept  (dec_accept),
    .dec_code    (dec_code),
    .purge_cmd   (purge_cmd),
    .tx_wait_flag(tx_wait_flag)
);

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  host_addr = 8'h00;
    logic        word_valid = 1'b0;
    logic        word_ready;
    logic [15:0] word_data = 16'h0000;
    logic [7:0]  rx_status = 8'h00;
    logic        pkt_end = 1'b0;
    logic        tx_wait_arm = 1'b0;
    logic        dec_valid;
    logic        dec_accept;
    logic [2:0]  dec_code;
    logic        purge_cmd;
    logic        tx_wait_flag;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_addr_filter i_rx_addr_filter (
        .clk         (clk),
        .rst         (rst),
        .host_addr   (host_addr),
        .word_valid  (word_valid),
        .word_ready  (word_ready),
        .word_data   (word_data),
        .rx_status   (rx_status),
        .pkt_end     (pkt_end),
        .tx_wait_arm (tx_wait_arm),
        .dec_valid   (dec_valid),
        .dec_accept  (dec_accept),
        .dec_code    (dec_code),
        .purge_cmd   (purge_cmd),
        .tx_wait_flag(tx_wait_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // offer one first word; on return the decision cycle is visible
    task automatic offer(input logic [15:0] w, input logic [7:0] s);
        @(negedge clk);
        word_valid = 1'b1;
        word_data  = w;
        rx_status  = s;
        @(negedge clk);
        word_valid = 1'b0;
        rx_status  = 8'h00;
    endtask

    task automatic end_packet();
        @(negedge clk);
        pkt_end = 1'b1;
        @(negedge clk);
        pkt_end = 1'b0;
    endtask

    task automatic expect_decision(input string req, input int acc, input int code);
        chk({req, " dec_valid"}, int'(dec_valid), 1);
        chk({req, " dec_accept"}, int'(dec_accept), acc);
        chk({req, " dec_code"}, int'(dec_code), code);
        chk({req, " purge_cmd"}, int'(purge_cmd), acc ? 0 : 1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R10 ready in reset", int'(word_ready), 1);
        chk("R10 dec_valid in reset", int'(dec_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 dec_valid", int'(dec_valid), 0);
        chk("R10 purge_cmd", int'(purge_cmd), 0);
        chk("R10 tx_wait_flag", int'(tx_wait_flag), 0);
        chk("R10 word_ready", int'(word_ready), 1);
    endtask

    task automatic t_promisc();
        host_addr = 8'h00;
        offer(16'h5A77, 8'h00);
        expect_decision("R3 promiscuous", 1, 2);
        @(negedge clk);
        chk("R7 strobe one cycle", int'(dec_valid), 0);
        end_packet();
        offer(16'h0000, 8'h00);
        expect_decision("R3 promiscuous zero dest", 1, 2);
        end_packet();
    endtask

    task automatic t_match();
        host_addr = 8'h23;
        offer(16'h2301, 8'h00);
        expect_decision("R4 own address", 1, 3);
        chk("R8 busy after accept", int'(word_ready), 0);
        end_packet();
        chk("R8 ready after end", int'(word_ready), 1);
    endtask

    task automatic t_bcast();
        host_addr = 8'h23;
        offer(16'h00FF, 8'h00);
        expect_decision("R5 broadcast", 1, 4);
        end_packet();
    endtask

    task automatic t_miss();
        host_addr = 8'h23;
        offer(16'h2423, 8'h00);
        expect_decision("R1 R6 low byte ignored, miss", 0, 1);
        chk("R6 ready after purge", int'(word_ready), 1);
        @(negedge clk);
        chk("R6 purge pulse one cycle", int'(purge_cmd), 0);
    endtask

    task automatic t_errors();
        host_addr = 8'h23;
        offer(16'h2300, 8'h80);
        expect_decision("R2 collision", 0, 0);
        host_addr = 8'h00;
        offer(16'h1111, 8'h01);
        expect_decision("R2 bad termination", 0, 0);
        host_addr = 8'h23;
        offer(16'h2300, 8'h7E);
        expect_decision("R2 other status bits ignored", 1, 3);
        end_packet();
    endtask

    task automatic t_busy_ignored();
        host_addr = 8'h23;
        offer(16'h2300, 8'h00);
        expect_decision("R8 accept before busy", 1, 3);
        @(negedge clk);
        word_valid = 1'b1;
        word_data  = 16'h9900;
        rx_status  = 8'h80;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8 no decision while busy", int'(dec_valid), 0);
            chk("R8 no purge while busy", int'(purge_cmd), 0);
        end
        word_valid = 1'b0;
        rx_status  = 8'h00;
        end_packet();
        offer(16'h9900, 8'h00);
        expect_decision("R8 next packet decided", 0, 1);
    endtask

    task automatic t_flag();
        host_addr = 8'h23;
        @(negedge clk);
        tx_wait_arm = 1'b1;
        @(negedge clk);
        tx_wait_arm = 1'b0;
        chk("R9 flag armed", int'(tx_wait_flag), 1);
        offer(16'h4400, 8'h00);
        chk("R9 purge keeps flag", int'(tx_wait_flag), 1);
        offer(16'h2300, 8'h00);
        chk("R9 accept clears flag", int'(tx_wait_flag), 0);
        end_packet();
        @(negedge clk);
        tx_wait_arm = 1'b1;
        word_valid  = 1'b1;
        word_data   = 16'h0012;
        @(negedge clk);
        tx_wait_arm = 1'b0;
        word_valid  = 1'b0;
        chk("R9 clear wins over arm", int'(tx_wait_flag), 0);
        chk("R9 broadcast accepted", int'(dec_accept), 1);
        end_packet();
    endtask

    task automatic t_end_same_cycle();
        host_addr = 8'h23;
        @(negedge clk);
        word_valid = 1'b1;
        word_data  = 16'h2355;
        pkt_end    = 1'b1;
        @(negedge clk);
        word_valid = 1'b0;
        pkt_end    = 1'b0;
        chk("R8 short packet accepted", int'(dec_accept), 1);
        chk("R8 short packet ready", int'(word_ready), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_promisc();
        t_match();
        t_bcast();
        t_miss();
        t_errors();
        t_busy_ignored();
        t_flag();
        t_end_same_cycle();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule